// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block drives the scan timing of a parallel TFT panel. It produces horizontal sync, vertical sync, data enable and a panel clock level. It also supplies a one-cycle pixel strobe that a pixel source uses to step through the frame. Three packed 32-bit timing words set the geometry: a horizontal word, a vertical word and a clock/polarity word. Fields in these words use two conventions. Some store the value minus one and some store it directly. The pixel divisor is split over two separate bit ranges.

Software writes the configuration through a small register write port. Timing words are accepted only while the enable bit is clear, so a running raster cannot be corrupted. Each line runs sync, back porch, active, then front porch. The vertical axis moves one line at the end of every full line. An active-pixel coordinate pair is driven during data enable. A frame event fires once per frame at a selectable vertical phase and sets a sticky status flag. That flag raises the interrupt output when the interrupt enable bit is set.

Top module: `raster_timing_gen`

## Requirements
- R1: The write port decodes address 0 as the horizontal word, 1 as the vertical word, 2 as the clock/polarity word, 3 as control and 4 as the status clear. A write to address 0, 1 or 2 is ignored while control bit 0 (enable) is 1.
- R2: The pixel divisor is D = {clk[31:27], clk[4:0]} + 2. While enabled, pix_ce_o pulses for one cycle out of every D. When clk[26] is 1 the divider is bypassed and pix_ce_o is high on every enabled cycle.
- R3: In pixel strobes, horizontal sync lasts hword[15:8]+1, back porch lasts hword[31:24]+1, active lasts (hword[7:2]+1)*16 and front porch lasts hword[23:16]+1, in that order, starting with sync.
- R4: In lines, vertical sync lasts vword[15:10]+1, back porch lasts vword[31:24], active lasts vword[9:0]+1 and front porch lasts vword[23:16], in that order. A zero porch field gives no lines. The line counter steps when the last pixel of a line is strobed.
- R5: Data enable is active only when both the horizontal and the vertical position are inside their active regions.
- R6: During data enable, x_o and y_o give the zero-based pixel column and row inside the active area. At all other times both are 0.
- R7: Bits 11, 12, 13 and 14 of the clock/polarity word invert vsync_o, hsync_o, pclk_o and de_o. While disabled, each output rests at its inactive level.
- R8: The raw panel clock is high for the first floor(D/2) cycles of each pixel period. In bypass mode or when disabled, the raw panel clock is low.
- R9: Control bits [13:12] select the frame event point: 0 is the start of vertical sync, 1 the start of back porch, 2 the start of active lines and 3 the start of front porch. The event occurs on the strobe of the first pixel of that line. A selected phase of zero length gives no event.
- R10: The frame event sets a sticky status bit. Writing 1 to bit 0 of address 4 clears it, and if a set and a clear fall in the same cycle the set wins. irq_o is the status ANDed with control bit 4, which resets to 0.
- R11: panel_pwr_o is control bit 11 ANDed with control bit 0, so power is never on while the raster is disabled.
- R12: After reset all registers are zero and hsync_o, vsync_o, de_o, pclk_o, pix_ce_o, irq_o, panel_pwr_o, x_o and y_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| pclk_o | output | 1 | Panel clock level after polarity |
| pix_ce_o | output | 1 | One-cycle pixel strobe |
| x_o | output | XY_W (10) | Active pixel column |
| y_o | output | XY_W (10) | Active pixel row |
| irq_o | output | 1 | Masked frame interrupt |
| panel_pwr_o | output | 1 | Panel power control |

## Verification
The frame event and a software clear of the status flag can land in the same clock cycle. The bench provokes this by predicting, from its own model of the raster, the exact cycle in which the selected event fires, and issuing the status-clear write in that same cycle. The result is judged at the interrupt output. It must still be high in the following cycle, and it must drop only after a later clear that has no coinciding event. The same cycle-by-cycle scoreboard compares every output while timing writes are attempted under enable and while zero-length porches are combined with the matching event select.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int CFG_W  = 32;
    localparam int LEN_W  = 12;
    localparam int DIVF_W = 10;

    localparam logic [2:0] A_HTIM = 3'd0;
    localparam logic [2:0] A_VTIM = 3'd1;
    localparam logic [2:0] A_CLK  = 3'd2;
    localparam logic [2:0] A_CTRL = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

    typedef enum logic [1:0] {
        EV_SYNC  = 2'd0,
        EV_BACK  = 2'd1,
        EV_ACT   = 2'd2,
        EV_FRONT = 2'd3
    } ev_sel_e;

    typedef struct packed {
        logic [LEN_W-1:0] sync;
        logic [LEN_W-1:0] back;
        logic [LEN_W-1:0] act;
        logic [LEN_W-1:0] front;
    } axis_len_t;

    typedef struct packed {
        logic              bypass;
        logic [DIVF_W-1:0] div_m2;
        logic              inv_v;
        logic              inv_h;
        logic              inv_c;
        logic              inv_de;
    } clk_cfg_t;

    typedef struct packed {
        logic    en;
        logic    ie;
        logic    pwr;
        ev_sel_e sel;
    } ctrl_t;

    // horizontal word: every field carries a minus-one offset, width in units of 16
    function automatic axis_len_t decode_h(input logic [CFG_W-1:0] w);
        axis_len_t r;
        r.sync  = LEN_W'(w[15:8])  + LEN_W'(1);
        r.back  = LEN_W'(w[31:24]) + LEN_W'(1);
        r.act   = LEN_W'({w[7:2], 4'b0000}) + LEN_W'(16);
        r.front = LEN_W'(w[23:16]) + LEN_W'(1);
        return r;
    endfunction

    // vertical word: sync and line count minus one, porches stored as is
    function automatic axis_len_t decode_v(input logic [CFG_W-1:0] w);
        axis_len_t r;
        r.sync  = LEN_W'(w[15:10]) + LEN_W'(1);
        r.back  = LEN_W'(w[31:24]);
        r.act   = LEN_W'(w[9:0]) + LEN_W'(1);
        r.front = LEN_W'(w[23:16]);
        return r;
    endfunction

    function automatic clk_cfg_t decode_c(input logic [CFG_W-1:0] w);
        clk_cfg_t r;
        r.bypass = w[26];
        r.div_m2 = {w[31:27], w[4:0]};
        r.inv_v  = w[11];
        r.inv_h  = w[12];
        r.inv_c  = w[13];
        r.inv_de = w[14];
        return r;
    endfunction

    function automatic ctrl_t decode_ctrl(input logic [CFG_W-1:0] w);
        ctrl_t r;
        r.en  = w[0];
        r.ie  = w[4];
        r.pwr = w[11];
        r.sel = ev_sel_e'(w[13:12]);
        return r;
    endfunction

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int AW   = 3,
    parameter int DW   = CFG_W,
    parameter int NTIM = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  logic                      ev_i,
    output logic [NTIM-1:0][DW-1:0]   tim_o,
    output logic [DW-1:0]             ctrl_o,
    output logic                      stat_o
);

    typedef struct packed {
        logic [NTIM-1:0][DW-1:0] tim;
        logic [DW-1:0]           ctrl;
        logic                    stat;
    } st_t;

    st_t  st_d, st_q;
    logic run_q;
    logic clr;

    assign run_q = st_q.ctrl[0];

    always_comb begin
        st_d = st_q;
        clr  = wr_en && (wr_addr == AW'(A_STAT)) && wr_data[0];
        for (int i = 0; i < NTIM; i++) begin
            if (wr_en && !run_q && (wr_addr == AW'(i))) begin
                st_d.tim[i] = wr_data;
            end
        end
        if (wr_en && (wr_addr == AW'(A_CTRL))) begin
            st_d.ctrl = wr_data;
        end
        st_d.stat = ev_i | (st_q.stat & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tim_o  = st_q.tim;
    assign ctrl_o = st_q.ctrl;
    assign stat_o = st_q.stat;

    // R1: timing words never move while the raster runs
    p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> $stable(st_q.tim));

    // R10: an event always leaves the flag set, clear or not
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i |=> st_q.stat);

    // R10: a clear with no event drops the flag
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev_i) |=> !st_q.stat);

endmodule

// File: rtl/rtg_pixdiv.sv
module rtg_pixdiv #(
    parameter int FW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          bypass,
    input  logic [FW-1:0] div_m2,
    output logic          ce,
    output logic          pclk_raw
);

    localparam int CW = FW + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] lim;
    logic [CW-1:0] half;

    always_comb begin
        lim      = CW'(div_m2) + CW'(1);
        half     = CW'(div_m2 >> 1) + CW'(1);
        ce       = en && (bypass || (st_q.cnt == lim));
        pclk_raw = en && !bypass && (st_q.cnt < half);
        st_d     = st_q;
        if (!en || bypass || (st_q.cnt == lim)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a divided strobe is never followed by another one (divisor >= 2)
    p_ce_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !bypass) |=> !ce);

    // R8: the clock level is high at the start of every divided period
    p_pclk_after_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !bypass && en) |=> (pclk_raw || !en));

endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         step,
    input  logic [W-1:0] len_sync,
    input  logic [W-1:0] len_back,
    input  logic [W-1:0] len_act,
    input  logic [W-1:0] len_front,
    output logic [W-1:0] pos,
    output logic [W-1:0] back_st,
    output logic [W-1:0] act_st,
    output logic [W-1:0] front_st,
    output logic         in_sync,
    output logic         in_act,
    output logic [W-1:0] act_idx,
    output logic         last
);

    typedef struct packed {
        logic [W-1:0] pos;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] total;

    always_comb begin
        back_st  = len_sync;
        act_st   = len_sync + len_back;
        front_st = act_st + len_act;
        total    = front_st + len_front;
        in_sync  = st_q.pos < back_st;
        in_act   = (st_q.pos >= act_st) && (st_q.pos < front_st);
        act_idx  = in_act ? (st_q.pos - act_st) : '0;
        last     = st_q.pos == (total - W'(1));
        st_d     = st_q;
        if (hold) begin
            st_d.pos = '0;
        end else if (step) begin
            st_d.pos = last ? '0 : (st_q.pos + W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos = st_q.pos;

    // R3: position stays inside the programmed line or frame
    p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (st_q.pos < total));

    // R4: a step on the last position wraps to the first
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (st_q.pos == '0));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int AW   = 3,
    parameter int XY_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [31:0]     wr_data,
    output logic            hsync_o,
    output logic            vsync_o,
    output logic            de_o,
    output logic            pclk_o,
    output logic            pix_ce_o,
    output logic [XY_W-1:0] x_o,
    output logic [XY_W-1:0] y_o,
    output logic            irq_o,
    output logic            panel_pwr_o
);

    localparam int NTIM = 3;

    logic [NTIM-1:0][CFG_W-1:0] tim;
    logic [CFG_W-1:0]           ctrl_w;
    logic                       stat;
    axis_len_t                  hl, vl;
    clk_cfg_t                   cc;
    ctrl_t                      ct;

    logic             ce, pclk_raw, v_step, frame_ev, ev_line;
    logic             hs_raw, vs_raw, de_raw;
    logic [LEN_W-1:0] h_pos, h_bst, h_ast, h_fst, h_idx;
    logic [LEN_W-1:0] v_pos, v_bst, v_ast, v_fst, v_idx;
    logic             h_sync, h_act, h_last;
    logic             v_sync, v_act, v_last;

    rtg_regs #(.AW(AW), .DW(CFG_W), .NTIM(NTIM)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ev_i    (frame_ev),
        .tim_o   (tim),
        .ctrl_o  (ctrl_w),
        .stat_o  (stat)
    );

    assign hl = decode_h(tim[0]);
    assign vl = decode_v(tim[1]);
    assign cc = decode_c(tim[2]);
    assign ct = decode_ctrl(ctrl_w);

    rtg_pixdiv #(.FW(DIVF_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ct.en),
        .bypass   (cc.bypass),
        .div_m2   (cc.div_m2),
        .ce       (ce),
        .pclk_raw (pclk_raw)
    );

    rtg_axis #(.W(LEN_W)) u_h (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (!ct.en),
        .step      (ce),
        .len_sync  (hl.sync),
        .len_back  (hl.back),
        .len_act   (hl.act),
        .len_front (hl.front),
        .pos       (h_pos),
        .back_st   (h_bst),
        .act_st    (h_ast),
        .front_st  (h_fst),
        .in_sync   (h_sync),
        .in_act    (h_act),
        .act_idx   (h_idx),
        .last      (h_last)
    );

    assign v_step = ce && h_last;

    rtg_axis #(.W(LEN_W)) u_v (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (!ct.en),
        .step      (v_step),
        .len_sync  (vl.sync),
        .len_back  (vl.back),
        .len_act   (vl.act),
        .len_front (vl.front),
        .pos       (v_pos),
        .back_st   (v_bst),
        .act_st    (v_ast),
        .front_st  (v_fst),
        .in_sync   (v_sync),
        .in_act    (v_act),
        .act_idx   (v_idx),
        .last      (v_last)
    );

    // frame event: first pixel strobe of the first line of the chosen phase
    always_comb begin
        ev_line = 1'b0;
        unique case (ct.sel)
            EV_SYNC:  ev_line = (v_pos == '0);
            EV_BACK:  ev_line = (v_pos == v_bst) && (vl.back != '0);
            EV_ACT:   ev_line = (v_pos == v_ast);
            EV_FRONT: ev_line = (v_pos == v_fst) && (vl.front != '0);
            default:  ev_line = 1'b0;
        endcase
        frame_ev = ce && (h_pos == '0) && ev_line;
    end

    always_comb begin
        hs_raw      = ct.en && h_sync;
        vs_raw      = ct.en && v_sync;
        de_raw      = ct.en && h_act && v_act;
        hsync_o     = hs_raw ^ cc.inv_h;
        vsync_o     = vs_raw ^ cc.inv_v;
        de_o        = de_raw ^ cc.inv_de;
        pclk_o      = pclk_raw ^ cc.inv_c;
        pix_ce_o    = ce;
        x_o         = de_raw ? XY_W'(h_idx) : '0;
        y_o         = de_raw ? XY_W'(v_idx) : '0;
        irq_o       = stat && ct.ie;
        panel_pwr_o = ct.pwr && ct.en;
    end

    // R5: the enable window never overlaps horizontal sync
    p_de_not_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(de_raw && hs_raw));

    // R10: interrupt output requires the enable bit
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ct.ie);

    // R11: power only while the raster runs
    p_pwr_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        panel_pwr_o |-> ct.en);

    // R4: the vertical axis steps only on the last pixel of a line
    p_vstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ct.en && !v_step && $past(ct.en)) |=> ($stable(v_pos) || !ct.en));

endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync_o, vsync_o, de_o, pclk_o, pix_ce_o, irq_o, panel_pwr_o;
    logic [9:0]  x_o, y_o;

    always #4 clk = ~clk;

    raster_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pclk_o(pclk_o),
        .pix_ce_o(pix_ce_o), .x_o(x_o), .y_o(y_o), .irq_o(irq_o), .panel_pwr_o(panel_pwr_o)
    );

    typedef struct {
        int hs; int vs; int de; int pc; int ce; int irq; int pwr; int x; int y;
    } exp_t;

    exp_t  expq[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string tag = "";

    // reference model state (what the design holds after the next edge)
    logic [31:0] m_h = '0, m_v = '0, m_c = '0, m_ctl = '0;
    int          m_div = 0, m_hp = 0, m_vp = 0;
    bit          m_stat = 0;

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s%s: actual %0d expected %0d at %0t", req, tag, act, exp, $time);
        end
    endtask

    function automatic int hs_l(); return int'(m_h[15:8]) + 1; endfunction
    function automatic int hb_l(); return int'(m_h[31:24]) + 1; endfunction
    function automatic int ha_l(); return (int'(m_h[7:2]) + 1) * 16; endfunction
    function automatic int hf_l(); return int'(m_h[23:16]) + 1; endfunction
    function automatic int vs_l(); return int'(m_v[15:10]) + 1; endfunction
    function automatic int vb_l(); return int'(m_v[31:24]); endfunction
    function automatic int va_l(); return int'(m_v[9:0]) + 1; endfunction
    function automatic int vf_l(); return int'(m_v[23:16]); endfunction
    function automatic int dvsr(); return int'({m_c[31:27], m_c[4:0]}) + 2; endfunction

    function automatic bit m_ce();
        return m_ctl[0] && (m_c[26] || (m_div == dvsr() - 1));
    endfunction

    function automatic bit m_event();
        bit line_ok;
        case (m_ctl[13:12])
            2'd0:    line_ok = (m_vp == 0);
            2'd1:    line_ok = (vb_l() != 0) && (m_vp == vs_l());
            2'd2:    line_ok = (m_vp == vs_l() + vb_l());
            default: line_ok = (vf_l() != 0) && (m_vp == vs_l() + vb_l() + va_l());
        endcase
        return m_ce() && (m_hp == 0) && line_ok;
    endfunction

    function automatic exp_t m_out();
        exp_t e;
        bit en, hin, vin, de;
        int h0, v0;
        en   = m_ctl[0];
        h0   = hs_l() + hb_l();
        v0   = vs_l() + vb_l();
        hin  = (m_hp >= h0) && (m_hp < h0 + ha_l());
        vin  = (m_vp >= v0) && (m_vp < v0 + va_l());
        de   = en && hin && vin;
        e.hs  = int'((en && (m_hp < hs_l())) ^ m_c[12]);
        e.vs  = int'((en && (m_vp < vs_l())) ^ m_c[11]);
        e.de  = int'(de ^ m_c[14]);
        e.pc  = int'((en && !m_c[26] && (m_div < dvsr() / 2)) ^ m_c[13]);
        e.ce  = int'(m_ce());
        e.irq = int'(m_stat && m_ctl[4]);
        e.pwr = int'(m_ctl[0] && m_ctl[11]);
        e.x   = de ? (m_hp - h0) : 0;
        e.y   = de ? (m_vp - v0) : 0;
        return e;
    endfunction

    task automatic m_advance(input bit we, input logic [2:0] a, input logic [31:0] d);
        bit en, ce, ev, clr, last_h;
        int htot, vtot;
        en   = m_ctl[0];
        ce   = m_ce();
        ev   = m_event();
        clr  = we && (a == 3'd4) && d[0];
        htot = hs_l() + hb_l() + ha_l() + hf_l();
        vtot = vs_l() + vb_l() + va_l() + vf_l();
        last_h = (m_hp == htot - 1);
        m_stat = ev || (m_stat && !clr);
        if (!en || m_c[26] || (m_div == dvsr() - 1)) m_div = 0; else m_div = m_div + 1;
        if (!en) begin
            m_hp = 0; m_vp = 0;
        end else if (ce) begin
            if (last_h) begin
                m_hp = 0;
                m_vp = (m_vp == vtot - 1) ? 0 : m_vp + 1;
            end else begin
                m_hp = m_hp + 1;
            end
        end
        if (we) begin
            if (a == 3'd0 && !en) m_h = d;
            if (a == 3'd1 && !en) m_v = d;
            if (a == 3'd2 && !en) m_c = d;
            if (a == 3'd3) m_ctl = d;
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected outputs
    task automatic step(input bit we, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        m_advance(we, a, d);
        expq.push_back(m_out());
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'h0);
    endtask

    task automatic clear_at_event();
        for (int i = 0; i < 2000; i++) begin
            if (m_event()) begin
                step(1'b1, 3'd4, 32'h1);
                return;
            end
            step(1'b0, 3'd0, 32'h0);
        end
        chk(0, 1, "R10 event not reached");
    endtask

    // monitor: compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (expq.size() != 0) begin
                exp_t e;
                e = expq.pop_front();
                chk(int'(pix_ce_o), e.ce, "R2 pix_ce");
                chk(int'(hsync_o), e.hs, "R3/R7 hsync");
                chk(int'(vsync_o), e.vs, "R4/R7 vsync");
                chk(int'(de_o), e.de, "R5/R7 de");
                chk(int'(x_o), e.x, "R6 x");
                chk(int'(y_o), e.y, "R6 y");
                chk(int'(pclk_o), e.pc, "R8 pclk");
                chk(int'(irq_o), e.irq, "R9/R10 irq");
                chk(int'(panel_pwr_o), e.pwr, "R11 power");
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete (all requirements)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(int'(hsync_o), 0, "R12 reset hsync");
        chk(int'(vsync_o), 0, "R12 reset vsync");
        chk(int'(de_o), 0, "R12 reset de");
        chk(int'(pclk_o), 0, "R12 reset pclk");
        chk(int'(pix_ce_o), 0, "R12 reset pix_ce");
        chk(int'(irq_o), 0, "R12 reset irq");
        chk(int'(panel_pwr_o), 0, "R12 reset power");
        chk(int'(x_o) + int'(y_o), 0, "R12 reset coords");

        // bypass clock, small frame, event at sync start, power on
        tag = " [R3]";
        step(1'b1, 3'd0, 32'h0001_0100);
        step(1'b1, 3'd1, 32'h0101_0002);
        step(1'b1, 3'd2, 32'h0400_0000);
        step(1'b1, 3'd3, 32'h0000_0811);
        run(300);
        step(1'b1, 3'd4, 32'h1);
        run(200);

        // timing writes while running must be ignored
        tag = " [R1]";
        step(1'b1, 3'd0, 32'hFFFF_FFFF);
        step(1'b1, 3'd1, 32'hFFFF_FFFF);
        step(1'b1, 3'd2, 32'h0000_7801);
        run(300);

        // divide by 3 with all polarities inverted, event at active start
        tag = " [R7]";
        step(1'b1, 3'd3, 32'h0);
        step(1'b1, 3'd2, 32'h0000_7801);
        step(1'b1, 3'd4, 32'h1);
        step(1'b1, 3'd3, 32'h0000_2011);
        run(800);

        // event select corners: empty back porch, empty front porch, normal back porch
        tag = " [R9]";
        step(1'b1, 3'd3, 32'h0);
        step(1'b1, 3'd4, 32'h1);
        step(1'b1, 3'd1, 32'h0001_0002);
        step(1'b1, 3'd2, 32'h0400_0000);
        step(1'b1, 3'd3, 32'h0000_1011);
        run(300);
        step(1'b1, 3'd3, 32'h0);
        step(1'b1, 3'd4, 32'h1);
        step(1'b1, 3'd1, 32'h0100_0002);
        step(1'b1, 3'd3, 32'h0000_3011);
        run(300);
        step(1'b1, 3'd3, 32'h0);
        step(1'b1, 3'd1, 32'h0101_0002);
        step(1'b1, 3'd3, 32'h0000_1011);
        run(300);

        // large divisor using only the high divisor field (D = 34)
        tag = " [R2]";
        step(1'b1, 3'd3, 32'h0);
        step(1'b1, 3'd2, 32'h0800_0000);
        step(1'b1, 3'd4, 32'h1);
        step(1'b1, 3'd3, 32'h0000_3011);
        run(9000);

        // set and clear in the same cycle, then a plain clear, then masking
        tag = " [R10]";
        step(1'b1, 3'd3, 32'h0);
        step(1'b1, 3'd2, 32'h0400_0000);
        step(1'b1, 3'd4, 32'h1);
        step(1'b1, 3'd3, 32'h0000_0011);
        clear_at_event();
        run(3);
        step(1'b1, 3'd4, 32'h1);
        run(50);
        step(1'b1, 3'd3, 32'h0000_0001);
        run(300);

        // power without enable stays off
        tag = " [R11]";
        step(1'b1, 3'd3, 32'h0000_0800);
        run(5);
        step(1'b1, 3'd3, 32'h0000_0801);
        run(5);
        step(1'b1, 3'd3, 32'h0);
        run(5);

        @(posedge clk);
        #4;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule